// File: doc/BRIEF.md
# ADC Oversampling Accumulator with Injected-Sequence Pre-emption

The block turns a stream of raw conversion results into oversampled results. For a regular channel it asks the converter for a burst of conversions, sums the returned samples over a programmable ratio, and divides the sum by a power of two with truncation. It can then scale the value up by a separate left shift before presenting it on a registered output. The block either runs the whole burst from one trigger or takes one trigger per conversion.

Injected sequences take priority over regular conversions. While an injected sequence is active, no regular conversion is requested. A regular conversion still in flight when the sequence starts is dropped and asked for again later. A mode input selects what happens to the partial regular sum. In keep mode the sum and sample count survive the sequence and accumulation continues afterwards. In restart mode the sum and count are cleared and the burst begins again from its first sample. Results that arrive during the injected sequence go to an accumulator of their own, or pass straight through when injected oversampling is off.

Top module: `ovs_accum`

## Requirements
- R1: While `rst` is high, and after it is released with no trigger, `conv_req_o`, `reg_valid_o` and `inj_valid_o` stay 0 and `reg_data_o` reads 0.
- R2: With regular oversampling on, a burst accumulates exactly `cfg_ratio`+1 regular samples. `reg_valid_o` pulses for one cycle, in the cycle after the last sample is accepted, once per burst.
- R3: The sum is right-shifted by `cfg_rshift` with truncation. Codes 11 to 15 act as a 10-bit shift.
- R4: After the right shift, the value is left-shifted by `cfg_lshift` (0 to 15). `reg_data_o` carries the low `OUT_W` bits of the outcome.
- R5: With `cfg_reg_en` = 0, each trigger yields one conversion. The result is the sample left-shifted by `cfg_lshift`, and `cfg_ratio` and `cfg_rshift` are ignored.
- R6: With `cfg_trig_each` = 0, one trigger runs the whole burst: each new request follows the previous result with no trigger needed. Triggers during a burst are ignored, and no request follows the final result.
- R7: With `cfg_trig_each` = 1, every conversion after the first waits for a new `trig_i` pulse that arrives while no injected sequence is active.
- R8: `conv_req_o` is a single-cycle pulse. It is never raised in the cycle after `inj_active_i` was sampled high. A regular conversion pending when an injected sequence starts is discarded and requested again after the sequence.
- R9: With `cfg_restart` = 0 (keep mode), an injected sequence leaves the regular sum and count intact. The finished result covers every sample delivered before and after the sequence.
- R10: With `cfg_restart` = 1, the start of an injected sequence clears the regular sum and count, and the burst restarts from its first sample. With `cfg_trig_each` = 1, the restarted burst first waits for a new trigger.
- R11: With `cfg_inj_en` = 1, results arriving while `inj_active_i` is high are summed from the sequence start. Every `cfg_ratio`+1 of them produce one `inj_valid_o` pulse, with the same right/left shifting as R3 and R4. These results never alter the regular sum.
- R12: With `cfg_inj_en` = 0, each injected result produces one `inj_valid_o` pulse carrying the sample left-shifted by `cfg_lshift`.
- R13: Regular configuration is captured by the trigger that starts a burst, and injected configuration at the sequence start. Changes during a burst do not affect that burst's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reg_en | input | 1 | Regular oversampling on |
| cfg_inj_en | input | 1 | Injected oversampling on |
| cfg_ratio | input | RATIO_W | Samples per burst minus one |
| cfg_rshift | input | 4 | Right shift of the sum, 0 to 10 |
| cfg_lshift | input | 4 | Left shift of the final value |
| cfg_trig_each | input | 1 | 1: one trigger per conversion |
| cfg_restart | input | 1 | 1: injected sequence restarts the regular burst |
| trig_i | input | 1 | Regular trigger |
| inj_active_i | input | 1 | Injected sequence in progress |
| conv_valid_i | input | 1 | Conversion result strobe |
| conv_data_i | input | SAMPLE_W | Conversion result |
| conv_req_o | output | 1 | Request one regular conversion |
| reg_valid_o | output | 1 | Regular result strobe |
| reg_data_o | output | OUT_W | Regular result |
| inj_valid_o | output | 1 | Injected result strobe |
| inj_data_o | output | OUT_W | Injected result |

## Verification
The regular path is driven with random ratios and shift codes in both trigger modes, which separates off-by-one sample counts from shift errors. A constant full-scale sample with a large ratio and the largest left shift exposes truncation at the output width, and a shift code above 10 exposes a missing clamp. Injected sequences are inserted at random points in both modes, with and without injected samples. Keep mode and restart mode then give different regular sums, and the injected sums show whether the two accumulators stay apart. Directed runs change the configuration mid-burst, withhold triggers in per-conversion mode, and turn off each accumulation path.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int SH_W    = 4;
  localparam int RSH_MAX = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_TRIG = 2'd3
  } reg_state_e;

  function automatic logic [SH_W-1:0] clamp_rsh(input logic [SH_W-1:0] code);
    return (code > SH_W'(RSH_MAX)) ? SH_W'(RSH_MAX) : code;
  endfunction
endpackage

// File: rtl/ovs_scale.sv
module ovs_scale
  import ovs_pkg::*;
#(
  parameter int IN_W  = 22,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  in_val,
  input  logic [SH_W-1:0]  rsh,
  input  logic [SH_W-1:0]  lsh,
  output logic [OUT_W-1:0] out_val
);
  localparam int WIDE_W = IN_W + (1 << SH_W) - 1;

  logic [IN_W-1:0]   shifted_dn;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    shifted_dn = in_val >> rsh;
    wide       = WIDE_W'(shifted_dn) << lsh;
  end

  generate
    if (OUT_W >= WIDE_W) begin : g_ext
      assign out_val = OUT_W'(wide);
    end else begin : g_trunc
      assign out_val = wide[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ovs_reg_ctrl.sv
module ovs_reg_ctrl
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RATIO_W  = 10,
  parameter int OUT_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic [RATIO_W-1:0]  cfg_ratio,
  input  logic [SH_W-1:0]     cfg_rshift,
  input  logic [SH_W-1:0]     cfg_lshift,
  input  logic                cfg_trig_each,
  input  logic                cfg_restart,
  input  logic                trig_i,
  input  logic                inj_active_i,
  input  logic                inj_rise_i,
  input  logic                conv_valid_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                conv_req_o,
  output logic                res_valid_o,
  output logic [OUT_W-1:0]    res_data_o,
  output logic                busy_o,
  output logic [RATIO_W-1:0]  cnt_o,
  output logic [RATIO_W-1:0]  ratio_o
);
  localparam int ACC_W = SAMPLE_W + RATIO_W;

  reg_state_e         state_q;
  logic [RATIO_W-1:0] cnt_q, ratio_q;
  logic [ACC_W-1:0]   acc_q, sum;
  logic [SH_W-1:0]    rsh_q, lsh_q;
  logic               each_q, restart_q;
  logic               req_q, vld_q;
  logic [OUT_W-1:0]   res_q, scaled;
  logic               last_sample, take_sample;

  always_comb begin
    sum         = acc_q + ACC_W'(conv_data_i);
    last_sample = (cnt_q == ratio_q);
    take_sample = conv_valid_i && !inj_active_i;
  end

  ovs_scale #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_scale (
    .in_val (sum),
    .rsh    (rsh_q),
    .lsh    (lsh_q),
    .out_val(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ratio_q   <= '0;
      acc_q     <= '0;
      rsh_q     <= '0;
      lsh_q     <= '0;
      each_q    <= 1'b0;
      restart_q <= 1'b0;
      req_q     <= 1'b0;
      vld_q     <= 1'b0;
      res_q     <= '0;
    end else begin
      req_q <= 1'b0;
      vld_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (trig_i) begin
          ratio_q   <= cfg_en ? cfg_ratio : '0;
          rsh_q     <= cfg_en ? clamp_rsh(cfg_rshift) : '0;
          lsh_q     <= cfg_lshift;
          each_q    <= cfg_trig_each;
          restart_q <= cfg_restart;
          acc_q     <= '0;
          cnt_q     <= '0;
          state_q   <= ST_REQ;
        end
      end else if (inj_rise_i) begin
        // injected sequence begins: pending conversion is lost
        if (restart_q) begin
          acc_q   <= '0;
          cnt_q   <= '0;
          state_q <= each_q ? ST_TRIG : ST_REQ;
        end else if (state_q == ST_WAIT) begin
          state_q <= ST_REQ;
        end
      end else begin
        case (state_q)
          ST_REQ: begin
            if (!inj_active_i) begin
              req_q   <= 1'b1;
              state_q <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (take_sample) begin
              if (last_sample) begin
                vld_q   <= 1'b1;
                res_q   <= scaled;
                state_q <= ST_IDLE;
              end else begin
                acc_q   <= sum;
                cnt_q   <= cnt_q + RATIO_W'(1);
                state_q <= each_q ? ST_TRIG : ST_REQ;
              end
            end
          end
          ST_TRIG: begin
            if (trig_i && !inj_active_i) state_q <= ST_REQ;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign conv_req_o  = req_q;
  assign res_valid_o = vld_q;
  assign res_data_o  = res_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign cnt_o       = cnt_q;
  assign ratio_o     = ratio_q;
endmodule

// File: rtl/ovs_inj_path.sv
module ovs_inj_path
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RATIO_W  = 10,
  parameter int OUT_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic [RATIO_W-1:0]  cfg_ratio,
  input  logic [SH_W-1:0]     cfg_rshift,
  input  logic [SH_W-1:0]     cfg_lshift,
  input  logic                inj_active_i,
  input  logic                inj_rise_i,
  input  logic                conv_valid_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                res_valid_o,
  output logic [OUT_W-1:0]    res_data_o
);
  localparam int ACC_W = SAMPLE_W + RATIO_W;

  logic               en_q;
  logic [RATIO_W-1:0] ratio_q, cnt_q;
  logic [SH_W-1:0]    rsh_q, lsh_q;
  logic [ACC_W-1:0]   acc_q;
  logic               vld_q;
  logic [OUT_W-1:0]   res_q;

  // effective settings: a sequence start uses the live configuration
  logic               eff_en;
  logic [RATIO_W-1:0] eff_ratio, base_cnt;
  logic [SH_W-1:0]    eff_rsh, eff_lsh, sc_rsh;
  logic [ACC_W-1:0]   base_acc, sum, sc_in;
  logic [OUT_W-1:0]   scaled;

  always_comb begin
    eff_en    = inj_rise_i ? cfg_en : en_q;
    eff_ratio = inj_rise_i ? cfg_ratio : ratio_q;
    eff_rsh   = inj_rise_i ? clamp_rsh(cfg_rshift) : rsh_q;
    eff_lsh   = inj_rise_i ? cfg_lshift : lsh_q;
    base_acc  = inj_rise_i ? '0 : acc_q;
    base_cnt  = inj_rise_i ? '0 : cnt_q;
    sum       = base_acc + ACC_W'(conv_data_i);
    sc_in     = eff_en ? sum : ACC_W'(conv_data_i);
    sc_rsh    = eff_en ? eff_rsh : '0;
  end

  ovs_scale #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_scale (
    .in_val (sc_in),
    .rsh    (sc_rsh),
    .lsh    (eff_lsh),
    .out_val(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      ratio_q <= '0;
      rsh_q   <= '0;
      lsh_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      vld_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (inj_rise_i) begin
        en_q    <= cfg_en;
        ratio_q <= cfg_ratio;
        rsh_q   <= clamp_rsh(cfg_rshift);
        lsh_q   <= cfg_lshift;
        cnt_q   <= '0;
        acc_q   <= '0;
      end
      if (conv_valid_i && inj_active_i) begin
        if (!eff_en) begin
          vld_q <= 1'b1;
          res_q <= scaled;
        end else if (base_cnt == eff_ratio) begin
          vld_q <= 1'b1;
          res_q <= scaled;
          cnt_q <= '0;
          acc_q <= '0;
        end else begin
          cnt_q <= base_cnt + RATIO_W'(1);
          acc_q <= sum;
        end
      end
    end
  end

  assign res_valid_o = vld_q;
  assign res_data_o  = res_q;
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RATIO_W  = 10,
  parameter int OUT_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_reg_en,
  input  logic                cfg_inj_en,
  input  logic [RATIO_W-1:0]  cfg_ratio,
  input  logic [SH_W-1:0]     cfg_rshift,
  input  logic [SH_W-1:0]     cfg_lshift,
  input  logic                cfg_trig_each,
  input  logic                cfg_restart,
  input  logic                trig_i,
  input  logic                inj_active_i,
  input  logic                conv_valid_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                conv_req_o,
  output logic                reg_valid_o,
  output logic [OUT_W-1:0]    reg_data_o,
  output logic                inj_valid_o,
  output logic [OUT_W-1:0]    inj_data_o
);
  logic               inj_q;
  logic               inj_rise;
  logic               reg_busy;
  logic [RATIO_W-1:0] reg_cnt, reg_ratio;

  always_ff @(posedge clk) begin
    if (rst) inj_q <= 1'b0;
    else     inj_q <= inj_active_i;
  end

  assign inj_rise = inj_active_i & ~inj_q;

  ovs_reg_ctrl #(.SAMPLE_W(SAMPLE_W), .RATIO_W(RATIO_W), .OUT_W(OUT_W)) u_reg (
    .clk          (clk),
    .rst          (rst),
    .cfg_en       (cfg_reg_en),
    .cfg_ratio    (cfg_ratio),
    .cfg_rshift   (cfg_rshift),
    .cfg_lshift   (cfg_lshift),
    .cfg_trig_each(cfg_trig_each),
    .cfg_restart  (cfg_restart),
    .trig_i       (trig_i),
    .inj_active_i (inj_active_i),
    .inj_rise_i   (inj_rise),
    .conv_valid_i (conv_valid_i),
    .conv_data_i  (conv_data_i),
    .conv_req_o   (conv_req_o),
    .res_valid_o  (reg_valid_o),
    .res_data_o   (reg_data_o),
    .busy_o       (reg_busy),
    .cnt_o        (reg_cnt),
    .ratio_o      (reg_ratio)
  );

  ovs_inj_path #(.SAMPLE_W(SAMPLE_W), .RATIO_W(RATIO_W), .OUT_W(OUT_W)) u_inj (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_inj_en),
    .cfg_ratio   (cfg_ratio),
    .cfg_rshift  (cfg_rshift),
    .cfg_lshift  (cfg_lshift),
    .inj_active_i(inj_active_i),
    .inj_rise_i  (inj_rise),
    .conv_valid_i(conv_valid_i),
    .conv_data_i (conv_data_i),
    .res_valid_o (inj_valid_o),
    .res_data_o  (inj_data_o)
  );
endmodule

// File: rtl/ovs_accum_chk.sv
module ovs_accum_chk #(
  parameter int RATIO_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               inj_active_i,
  input logic               conv_valid_i,
  input logic               conv_req_o,
  input logic               reg_valid_o,
  input logic               inj_valid_o,
  input logic               reg_busy,
  input logic [RATIO_W-1:0] reg_cnt,
  input logic [RATIO_W-1:0] reg_ratio
);
  // R8: request is a single pulse
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_req_o |=> !conv_req_o);

  // R8: no request right after an active injected sequence was seen
  a_r8_req_quiet_inj: assert property (@(posedge clk) disable iff (rst)
    conv_req_o |-> !$past(inj_active_i));

  // R2: regular result only follows an accepted regular sample
  a_r2_result_after_sample: assert property (@(posedge clk) disable iff (rst)
    reg_valid_o |-> $past(conv_valid_i && !inj_active_i));

  // R2: one-cycle result strobe
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    reg_valid_o |=> !reg_valid_o);

  // R11: injected result only follows an injected sample
  a_r11_inj_after_sample: assert property (@(posedge clk) disable iff (rst)
    inj_valid_o |-> $past(conv_valid_i && inj_active_i));

  // R2: sample index never passes the captured ratio
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    reg_busy |-> (reg_cnt <= reg_ratio));
endmodule

bind ovs_accum ovs_accum_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inj_active_i(inj_active_i),
  .conv_valid_i(conv_valid_i),
  .conv_req_o  (conv_req_o),
  .reg_valid_o (reg_valid_o),
  .inj_valid_o (inj_valid_o),
  .reg_busy    (reg_busy),
  .reg_cnt     (reg_cnt),
  .reg_ratio   (reg_ratio)
);

// File: tb/tb_ovs_accum.sv
module tb_ovs_accum;
  localparam int SW = 12;
  localparam int RW = 10;
  localparam int OW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          cfg_reg_en, cfg_inj_en, cfg_trig_each, cfg_restart;
  logic [RW-1:0] cfg_ratio;
  logic [3:0]    cfg_rshift, cfg_lshift;
  logic          trig, inj_active, conv_valid;
  logic [SW-1:0] conv_data;
  logic          conv_req_o, reg_valid_o, inj_valid_o;
  logic [OW-1:0] reg_data_o, inj_data_o;

  ovs_accum #(.SAMPLE_W(SW), .RATIO_W(RW), .OUT_W(OW)) dut (
    .clk(clk), .rst(rst),
    .cfg_reg_en(cfg_reg_en), .cfg_inj_en(cfg_inj_en), .cfg_ratio(cfg_ratio),
    .cfg_rshift(cfg_rshift), .cfg_lshift(cfg_lshift),
    .cfg_trig_each(cfg_trig_each), .cfg_restart(cfg_restart),
    .trig_i(trig), .inj_active_i(inj_active),
    .conv_valid_i(conv_valid), .conv_data_i(conv_data),
    .conv_req_o(conv_req_o), .reg_valid_o(reg_valid_o), .reg_data_o(reg_data_o),
    .inj_valid_o(inj_valid_o), .inj_data_o(inj_data_o)
  );

  int checks = 0;
  int errors = 0;

  // converter model state, owned by drive_loop except where noted
  int     want_inj = 0, restart_tb = 0, feed = 0, fixed_val = -1, pending = 0;
  longint tally = 0, inj_sum = 0;
  int     ntally = 0, inj_n = 0, inj_last = 0;
  int     res_cnt = 0, inj_res_cnt = 0, req_cnt = 0, bad_req = 0;
  longint res_data = 0, inj_res_data = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_scale(input longint sum, input int rsh, input int lsh);
    int r;
    r = (rsh > 10) ? 10 : rsh;
    return ((sum >> r) << lsh) & 64'hFFFF_FFFF;
  endfunction

  function automatic int next_sample();
    return (fixed_val >= 0) ? fixed_val : int'($urandom_range(4095, 0));
  endfunction

  // one thread observes outputs and drives converter-side inputs at negedge
  task automatic drive_loop();
    forever begin
      @(negedge clk);
      if (reg_valid_o) begin res_cnt++; res_data = longint'(reg_data_o); end
      if (inj_valid_o) begin inj_res_cnt++; inj_res_data = longint'(inj_data_o); end
      if (conv_req_o) begin
        req_cnt++;
        if (inj_active) bad_req++;
      end
      begin
        logic was;
        int   d;
        was = inj_active;
        conv_valid = 1'b0;
        if (want_inj != 0 && !inj_active) begin
          inj_active = 1'b1;
          inj_sum = 0; inj_n = 0;
          if (restart_tb != 0) begin tally = 0; ntally = 0; end
        end else if (want_inj == 0) begin
          inj_active = 1'b0;
        end
        if (inj_active && was && feed > 0) begin
          d = next_sample();
          conv_valid = 1'b1; conv_data = SW'(d);
          inj_sum += d; inj_n++; inj_last = d; feed--;
        end else if (!inj_active && pending > 0) begin
          pending--;
          if (pending == 0) begin
            d = next_sample();
            conv_valid = 1'b1; conv_data = SW'(d);
            tally += d; ntally++;
          end
        end
        if (conv_req_o) pending = 2;
        if (inj_active) pending = 0;
      end
    end
  endtask

  task automatic run_burst(input int ratio, input int rsh, input int lsh, input int each,
                           input int restart, input int inj_at, input int inj_feed,
                           input int inj_en, input int reg_en, input int chg,
                           input string tag);
    int  s_res, s_inj, hold, req_done;
    bit  injected, changed, done;
    cfg_ratio = RW'(ratio); cfg_rshift = 4'(rsh); cfg_lshift = 4'(lsh);
    cfg_trig_each = each[0]; cfg_restart = restart[0];
    cfg_inj_en = inj_en[0]; cfg_reg_en = reg_en[0];
    restart_tb = restart;
    tally = 0; ntally = 0;
    s_res = res_cnt; s_inj = inj_res_cnt;
    hold = 0; injected = 0; changed = 0; done = 0;
    for (int cyc = 0; cyc < 20000 && !done; cyc++) begin
      @(negedge clk); #1;
      if (res_cnt > s_res) done = 1;
      else begin
        if (inj_at >= 0 && !injected && ntally >= inj_at) begin
          want_inj = 1; feed = inj_feed; injected = 1; hold = inj_feed + 4;
        end else if (want_inj != 0) begin
          if (hold > 0) hold--; else want_inj = 0;
        end
        if (chg != 0 && !changed && ntally >= 1) begin
          cfg_rshift = 4'(rsh + 3); cfg_lshift = 4'(lsh + 2);
          cfg_ratio = RW'(ratio + 3); cfg_reg_en = 1'b0; changed = 1;
        end
        trig = (cyc % 5 == 0) && (want_inj == 0);
      end
    end
    trig = 1'b0; want_inj = 0;
    req_done = req_cnt;
    repeat (12) @(negedge clk);
    #1;
    check({tag, " one result per burst"}, res_cnt - s_res, 1);
    check({tag, " result value"}, res_data, exp_scale(tally, (reg_en != 0) ? rsh : 0, lsh));
    check({tag, " samples in result"}, ntally, (reg_en != 0) ? ratio + 1 : 1);
    check({tag, " R6 no request after result"}, req_cnt, req_done);
    if (inj_at >= 0) check({tag, " R8 no request during injection"}, bad_req, 0);
    if (inj_at >= 0 && inj_feed > 0) begin
      if (inj_en != 0) begin
        check({tag, " R11 injected count"}, inj_res_cnt - s_inj, (inj_feed == ratio + 1) ? 1 : 0);
        if (inj_feed == ratio + 1)
          check({tag, " R11 injected value"}, inj_res_data, exp_scale(inj_sum, rsh, lsh));
      end else begin
        check({tag, " R12 injected pass count"}, inj_res_cnt - s_inj, inj_feed);
        check({tag, " R12 injected pass value"}, inj_res_data,
              exp_scale(longint'(inj_last), 0, lsh));
      end
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int s_req, s_res, dummy;
    dummy = int'($urandom(32'd4242));
    rst = 1'b1; trig = 1'b0; inj_active = 1'b0; conv_valid = 1'b0; conv_data = '0;
    cfg_reg_en = 1'b1; cfg_inj_en = 1'b0; cfg_ratio = '0; cfg_rshift = '0; cfg_lshift = '0;
    cfg_trig_each = 1'b0; cfg_restart = 1'b0;
    fork drive_loop(); join_none
    repeat (3) @(negedge clk);
    #1;
    check("R1 req in reset", longint'(conv_req_o), 0);
    check("R1 valid in reset", longint'(reg_valid_o), 0);
    check("R1 inj valid in reset", longint'(inj_valid_o), 0);
    check("R1 data in reset", longint'(reg_data_o), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    check("R1 idle without trigger", req_cnt + res_cnt + inj_res_cnt, 0);

    // directed corners
    run_burst(3, 13, 0, 0, 0, -1, 0, 0, 1, 0, "R3 clamp");
    run_burst(0, 0, 5, 0, 0, -1, 0, 0, 1, 0, "R2 ratio one");
    fixed_val = 4095;
    run_burst(255, 0, 15, 0, 0, -1, 0, 0, 1, 0, "R4 truncation");
    fixed_val = -1;
    run_burst(5, 4, 3, 0, 0, -1, 0, 0, 0, 0, "R5 regular off");
    run_burst(4, 2, 1, 0, 0, -1, 0, 0, 1, 1, "R13 midburst change");
    run_burst(5, 3, 0, 0, 0, 2, 6, 1, 1, 0, "R9 keep with R11");
    run_burst(5, 3, 0, 0, 1, 3, 0, 0, 1, 0, "R10 restart burst");
    run_burst(3, 1, 2, 1, 1, 2, 0, 0, 1, 0, "R10 restart each");
    run_burst(4, 2, 4, 0, 0, 1, 3, 0, 1, 0, "R12 pass with R9");

    // R7: without further triggers a per-conversion burst stalls
    cfg_reg_en = 1'b1; cfg_trig_each = 1'b1; cfg_restart = 1'b0;
    cfg_ratio = RW'(2); cfg_rshift = 4'd1; cfg_lshift = 4'd0;
    tally = 0; ntally = 0; s_req = req_cnt; s_res = res_cnt;
    @(negedge clk); #1 trig = 1'b1;
    @(negedge clk); #1 trig = 1'b0;
    repeat (30) @(negedge clk);
    #1;
    check("R7 one request per trigger", req_cnt - s_req, 1);
    check("R7 stalled without trigger", res_cnt - s_res, 0);
    for (int k = 0; k < 2; k++) begin
      trig = 1'b1;
      @(negedge clk); #1 trig = 1'b0;
      repeat (15) @(negedge clk);
      #1;
    end
    check("R7 result after triggers", res_cnt - s_res, 1);
    check("R7 result value", res_data, exp_scale(tally, 1, 0));

    // random regular bursts, both trigger modes (R2 R3 R4 R6 R7)
    for (int i = 0; i < 14; i++) begin
      run_burst(int'($urandom_range(7, 0)), int'($urandom_range(15, 0)),
                int'($urandom_range(15, 0)), int'($urandom_range(1, 0)),
                0, -1, 0, 0, 1, 0, "R2/R6/R7 random");
    end

    // random injections in keep and restart modes (R8 R9 R10 R11)
    for (int i = 0; i < 8; i++) begin
      int r, en;
      r  = int'($urandom_range(6, 2));
      en = int'($urandom_range(1, 0));
      run_burst(r, int'($urandom_range(10, 0)), int'($urandom_range(6, 0)),
                int'($urandom_range(1, 0)), i % 2, int'($urandom_range(r, 1)),
                (en != 0) ? r + 1 : 2, en, 1, 0,
                (i % 2 != 0) ? "R10 random inject" : "R9 random inject");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule